// File: doc/BRIEF.md
# Banked Word Memory with Per-Bank Sleep

This block is a synchronous single-port word memory split into 32 banks. An access is steered through a chain of decoders. A one-hot bank select comes first. Two row decoders follow, and the second row decoder is enabled by the first. A final decode picks one word out of the selected row. Only the selected bank sees the access, and read data leaves the block only through that bank's output gate.

Each bank carries a sleep flag. A sleeping bank keeps its contents but cannot be read or written. A request to a sleeping bank first wakes it, and `ready` stays low for that one wake-up cycle. When a request is accepted, every bank other than its target is put back to sleep. An idle cycle puts every bank to sleep. A requester therefore pays one stall cycle whenever it moves to a new bank or comes back after an idle cycle. Streams of requests to the same bank run at one access per cycle.

The default geometry has 2048 words, with 2-bit upper and lower row fields. This keeps the storage small. Setting both row parameters to 4 gives the full 1 Mbit array with a 15-bit address, and the field order stays the same.

Top module: `drowsy_sram`

## Requirements
- R1: After reset every bank is asleep, `bank_awake` is all zero, `rvalid` is 0, `rdata` is 0, and `ready` is 1 while `req` is low.
- R2: With the default parameters, addr[10:6] selects the bank, addr[5:4] the upper row group, addr[3:2] the row within that group, and addr[1:0] the word in the row. Every distinct address, from 0 to 2047, holds its own word.
- R3: A request to a sleeping bank holds `ready` low for exactly one cycle. In the next cycle `ready` is high and the access is carried out.
- R4: A request to the bank that is already awake is accepted in the same cycle, with no stall.
- R5: Bit i of `bank_awake` is 1 when bank i is awake. At most one bit is ever set. After a cycle with `req` high, only the target bank is awake. After a cycle with `req` low, no bank is awake.
- R6: A read accepted at a clock edge raises `rvalid` for exactly one cycle after that edge, with the addressed word on `rdata`. `rdata` is 0 whenever `rvalid` is low.
- R7: A write changes only the addressed word. Neighbouring words in the same row, neighbouring rows, and the same offset in other banks are left unchanged. A write never raises `rvalid`.
- R8: A bank keeps every word exactly while it sleeps, across any number of accesses to other banks and any number of idle cycles.
- R9: A request held through a wake-up stall is performed exactly once. A held write stores its data, and a held read produces exactly one `rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request; must be held stable while `ready` is low |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 11 | Word address: bank, upper row, lower row, word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid`, 0 otherwise |
| rvalid | output | 1 | One-cycle read-data strobe |
| ready | output | 1 | High when the current request is accepted at the next edge |
| bank_awake | output | 32 | One bit per bank, 1 when that bank is awake |

## Verification
Two things can happen in the same cycle: the read data from an accepted read is returned, and the next request is stalled while its bank wakes up. The bench provokes this by reading from one bank and then, in the very next cycle, requesting a different bank or coming back after an idle cycle. In that cycle `rvalid` and the returned word must appear while `ready` is low. The held request must then complete once, one cycle later. A behavioural model tracks the word store, the single awake bank and the pending read result. It is compared against every output on every clock, so the overlap of returned data and stall is judged cycle by cycle.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

    // Kind of work the control step performs in a cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WAKE  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
    parameter int BANK_BITS = 5,
    parameter int HI_BITS   = 2,
    parameter int LO_BITS   = 2,
    parameter int WORD_BITS = 2,
    localparam int ADDR_W   = BANK_BITS + HI_BITS + LO_BITS + WORD_BITS,
    localparam int NBANK    = 1 << BANK_BITS,
    localparam int NHI      = 1 << HI_BITS,
    localparam int NLO      = 1 << LO_BITS,
    localparam int NROW     = NHI * NLO,
    localparam int NWORD    = 1 << WORD_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NBANK-1:0]  bank_sel,
    output logic [NROW-1:0]   row_sel,
    output logic [NWORD-1:0]  word_sel
);
    localparam int LO_BASE = WORD_BITS;
    localparam int HI_BASE = WORD_BITS + LO_BITS;
    localparam int BK_BASE = WORD_BITS + LO_BITS + HI_BITS;

    logic [BANK_BITS-1:0] bank_f;
    logic [HI_BITS-1:0]   hi_f;
    logic [LO_BITS-1:0]   lo_f;
    logic [WORD_BITS-1:0] word_f;
    logic [NHI-1:0]       hi_sel;

    assign bank_f = addr[BK_BASE +: BANK_BITS];
    assign hi_f   = addr[HI_BASE +: HI_BITS];
    assign lo_f   = addr[LO_BASE +: LO_BITS];
    assign word_f = addr[0 +: WORD_BITS];

    // First level: bank, gated by the accept strobe.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_sel[b] = en && (bank_f == BANK_BITS'(b));
    end

    // Upper row decoder enables each group of the lower row decoder.
    for (genvar h = 0; h < NHI; h++) begin : g_hi
        assign hi_sel[h] = (hi_f == HI_BITS'(h));
        for (genvar l = 0; l < NLO; l++) begin : g_lo
            assign row_sel[h*NLO + l] = hi_sel[h] && (lo_f == LO_BITS'(l));
        end
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign word_sel[w] = (word_f == WORD_BITS'(w));
    end

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int NROW   = 16,
    parameter int NWORD  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              sel,
    input  logic              we,
    input  logic [NROW-1:0]   row_sel,
    input  logic [NWORD-1:0]  word_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_gated
);
    logic [DATA_W-1:0] cells [NROW][NWORD];
    logic [DATA_W-1:0] rd_raw;

    // Only the selected word's columns are written.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NROW; r++) begin
            for (int w = 0; w < NWORD; w++) begin
                if (sel && we && row_sel[r] && word_sel[w]) begin
                    cells[r][w] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rd_raw = '0;
        for (int r = 0; r < NROW; r++) begin
            for (int w = 0; w < NWORD; w++) begin
                if (row_sel[r] && word_sel[w]) begin
                    rd_raw = rd_raw | cells[r][w];
                end
            end
        end
    end

    // Output gate: a bank drives nothing unless it is selected for a read.
    assign rd_gated = (sel && !we) ? rd_raw : '0;

endmodule

// File: rtl/drowsy_sram.sv
module drowsy_sram #(
    parameter int BANK_BITS   = 5,
    parameter int HI_ROW_BITS = 2,
    parameter int LO_ROW_BITS = 2,
    parameter int WORD_BITS   = 2,
    parameter int DATA_W      = 32,
    localparam int ADDR_W     = BANK_BITS + HI_ROW_BITS + LO_ROW_BITS + WORD_BITS,
    localparam int NBANK      = 1 << BANK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ready,
    output logic [NBANK-1:0]  bank_awake
);
    import dsram_pkg::*;

    localparam int NROW  = 1 << (HI_ROW_BITS + LO_ROW_BITS);
    localparam int NWORD = 1 << WORD_BITS;

    typedef struct packed {
        logic [NBANK-1:0]  awake;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t               st_q, st_d;
    acc_kind_e            kind;
    logic [BANK_BITS-1:0] bank_idx;
    logic                 target_awake;
    logic                 go;
    logic [NBANK-1:0]     bank_sel;
    logic [NROW-1:0]      row_sel;
    logic [NWORD-1:0]     word_sel;
    logic [DATA_W-1:0]    bank_rd [NBANK];
    logic [DATA_W-1:0]    gathered;

    assign bank_idx     = addr[ADDR_W-1 -: BANK_BITS];
    assign target_awake = st_q.awake[bank_idx];
    assign go           = req && target_awake;

    sram_addr_decode #(
        .BANK_BITS (BANK_BITS),
        .HI_BITS   (HI_ROW_BITS),
        .LO_BITS   (LO_ROW_BITS),
        .WORD_BITS (WORD_BITS)
    ) u_dec (
        .addr     (addr),
        .en       (go),
        .bank_sel (bank_sel),
        .row_sel  (row_sel),
        .word_sel (word_sel)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_banks
        sram_bank #(
            .NROW   (NROW),
            .NWORD  (NWORD),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk      (clk),
            .sel      (bank_sel[b]),
            .we       (we),
            .row_sel  (row_sel),
            .word_sel (word_sel),
            .wdata    (wdata),
            .rd_gated (bank_rd[b])
        );
    end

    // Gated outputs are wire-ORed; at most one bank is non-zero.
    always_comb begin
        gathered = '0;
        for (int b = 0; b < NBANK; b++) begin
            gathered = gathered | bank_rd[b];
        end
    end

    always_comb begin
        if (!req) begin
            kind = ACC_IDLE;
        end else if (!target_awake) begin
            kind = ACC_WAKE;
        end else if (we) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_READ;
        end

        st_d        = st_q;
        st_d.awake  = (kind == ACC_IDLE) ? '0 : (NBANK'(1) << bank_idx);
        st_d.rvalid = (kind == ACC_READ);
        st_d.rdata  = (kind == ACC_READ) ? gathered : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = !req || target_awake;
    assign rvalid     = st_q.rvalid;
    assign rdata      = st_q.rdata;
    assign bank_awake = st_q.awake;

endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
    parameter int BANK_BITS = 5,
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 32,
    parameter int NBANK     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              ready,
    input logic [NBANK-1:0]  bank_awake
);
    logic [BANK_BITS-1:0] bank_f;
    assign bank_f = addr[ADDR_W-1 -: BANK_BITS];

    // R1: with no request the port is always ready
    a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> ready);

    // R5: never more than one bank awake
    a_r5_single_awake: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_awake));

    // R5: an idle cycle puts every bank to sleep
    a_r5_idle_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (bank_awake == '0));

    // R5: a request leaves exactly one bank awake
    a_r5_req_wakes_one: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ($countones(bank_awake) == 1));

    // R3: the wake-up stall lasts a single cycle
    a_r3_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ready) |=> (!req || ready));

    // R4: back-to-back requests to the same bank do not stall
    a_r4_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (!req || (bank_f != $past(bank_f)) || ready));

    // R6: an accepted read returns a strobe one cycle later
    a_r6_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |=> rvalid);

    // R6: output gate keeps rdata at zero outside the strobe
    a_r6_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    // R7: writes and stalls never raise the read strobe
    a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!req || we || !ready) |=> !rvalid);

endmodule

bind drowsy_sram sram_checker #(
    .BANK_BITS (BANK_BITS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NBANK     (NBANK)
) u_sram_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .we         (we),
    .addr       (addr),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .ready      (ready),
    .bank_awake (bank_awake)
);

// File: tb/tb_drowsy_sram.sv
module tb_drowsy_sram;
    localparam int AW = 11;
    localparam int NB = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          ready;
    logic [NB-1:0] bank_awake;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    logic [DW-1:0] mm [0:(1<<AW)-1];
    logic [NB-1:0] m_awake = '0;
    bit            m_rvalid = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    bit            obs_rvalid;
    logic [DW-1:0] obs_rdata;

    drowsy_sram dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .ready      (ready),
        .bank_awake (bank_awake)
    );

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] ad(int bk, int row, int wd);
        return AW'(bk * 64 + row * 4 + wd);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One clock: drive at the falling edge, compare, advance the model.
    task automatic step(input bit r, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output bit acc);
        bit exp_ready;
        int b;
        req = r; we = w; addr = a; wdata = d;
        #1;
        b = int'(a >> 6);
        exp_ready = !r || m_awake[b];
        chk(ready === exp_ready, "R3 ready", 64'(ready), 64'(exp_ready));
        chk(bank_awake === m_awake, "R5 bank_awake", 64'(bank_awake), 64'(m_awake));
        chk(rvalid === m_rvalid, "R6 rvalid", 64'(rvalid), 64'(m_rvalid));
        chk(rdata === m_rdata, "R6 rdata", 64'(rdata), 64'(m_rdata));
        obs_rvalid = rvalid;
        obs_rdata  = rdata;
        acc = r && exp_ready;
        if (acc && w) mm[a] = d;
        m_rvalid = acc && !w;
        m_rdata  = (acc && !w) ? mm[a] : '0;
        m_awake  = r ? (NB'(1) << b) : '0;
        @(negedge clk);
    endtask

    task automatic access(input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output int stalls);
        bit acc;
        stalls = 0;
        repeat (4) begin
            step(1'b1, w, a, d, acc);
            if (acc) break;
            stalls++;
        end
    endtask

    task automatic idle();
        bit acc;
        step(1'b0, 1'b0, '0, '0, acc);
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                               input string tag);
        int s;
        access(1'b0, a, '0, s);
        idle();
        chk(obs_rvalid && (obs_rdata === exp), tag, 64'(obs_rdata), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        int s;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(ready === 1'b1, "R1 ready", 64'(ready), 64'd1);
        chk(bank_awake === '0, "R1 bank_awake", 64'(bank_awake), 64'd0);
        chk(rvalid === 1'b0, "R1 rvalid", 64'(rvalid), 64'd0);
        chk(rdata === '0, "R1 rdata", 64'(rdata), 64'd0);
        @(negedge clk);

        // R3: first access to a sleeping bank stalls once
        access(1'b1, ad(3, 5, 1), 32'hA5A5_0001, s);
        chk(s == 1, "R3 stall count", 64'(s), 64'd1);
        // R4: same bank again, no stall
        access(1'b1, ad(3, 6, 2), 32'hA5A5_0002, s);
        chk(s == 0, "R4 stall count", 64'(s), 64'd0);
        // R5: new bank stalls and the old one sleeps
        access(1'b1, ad(9, 0, 0), 32'h0909_0000, s);
        chk(s == 1, "R5 bank switch stall", 64'(s), 64'd1);
        chk(bank_awake === (NB'(1) << 9), "R5 only target awake",
            64'(bank_awake), 64'(NB'(1) << 9));
        idle();
        chk(bank_awake === '0, "R5 idle sleeps all", 64'(bank_awake), 64'd0);

        // R2 / R7: neighbours keep their own words
        access(1'b1, ad(12, 7, 0), 32'h1111_1111, s);
        access(1'b1, ad(12, 7, 1), 32'h2222_2222, s);
        access(1'b1, ad(12, 6, 0), 32'h3333_3333, s);
        access(1'b1, ad(12, 3, 0), 32'h4444_4444, s);
        access(1'b1, ad(13, 7, 0), 32'h5555_5555, s);
        idle();
        chk(obs_rvalid == 1'b0, "R7 write no rvalid", 64'(obs_rvalid), 64'd0);
        access(1'b1, ad(12, 7, 0), 32'h6666_6666, s);
        read_expect(ad(12, 7, 1), 32'h2222_2222, "R7 same row word");
        read_expect(ad(12, 6, 0), 32'h3333_3333, "R7 adjacent row");
        read_expect(ad(12, 3, 0), 32'h4444_4444, "R7 other upper row");
        read_expect(ad(13, 7, 0), 32'h5555_5555, "R7 other bank");
        read_expect(ad(12, 7, 0), 32'h6666_6666, "R2 overwritten word");

        // R2: boundary addresses
        access(1'b1, AW'(0), 32'hDEAD_0000, s);
        access(1'b1, AW'((1 << AW) - 1), 32'hBEEF_07FF, s);
        read_expect(AW'(0), 32'hDEAD_0000, "R2 lowest address");
        read_expect(AW'((1 << AW) - 1), 32'hBEEF_07FF, "R2 highest address");

        // R2: pattern sweep over one bank, every row and word
        for (int i = 0; i < 64; i++) begin
            access(1'b1, ad(20, i / 4, i % 4), 32'hC000_0000 | 32'(i * 7), s);
        end
        for (int i = 0; i < 64; i += 5) begin
            read_expect(ad(20, i / 4, i % 4), 32'hC000_0000 | 32'(i * 7), "R2 sweep");
        end

        // R8: retention through long sleep and traffic elsewhere
        access(1'b1, ad(7, 15, 3), 32'h7777_ABCD, s);
        for (int k = 0; k < 10; k++) begin
            access(1'b1, ad(k + 21, k, 0), 32'(k), s);
            idle();
        end
        repeat (20) idle();
        read_expect(ad(7, 15, 3), 32'h7777_ABCD, "R8 retained word");

        // R9: a read held through the stall gives one strobe
        idle();
        access(1'b0, ad(3, 5, 1), '0, s);
        chk(s == 1, "R9 held read stalled", 64'(s), 64'd1);
        cnt = 0;
        repeat (3) begin
            idle();
            cnt += int'(obs_rvalid);
        end
        chk(cnt == 1, "R9 single strobe", 64'(cnt), 64'd1);
        // R9: a write held through the stall stores once
        access(1'b1, ad(30, 2, 2), 32'h3030_2222, s);
        chk(s == 1, "R9 held write stalled", 64'(s), 64'd1);
        read_expect(ad(30, 2, 2), 32'h3030_2222, "R9 held write stored");

        // Overlap: read return while the next bank wakes
        access(1'b0, ad(12, 7, 1), '0, s);
        access(1'b0, ad(13, 7, 0), '0, s);
        chk(s == 1, "R3 stall during returned data", 64'(s), 64'd1);
        idle();
        chk(obs_rdata === 32'h5555_5555, "R6 data after overlap",
            64'(obs_rdata), 64'h5555_5555);

        repeat (2) idle();
        summary();
        $finish;
    end

endmodule